// File: doc/BRIEF.md
# Counter-Ramp Conversion Controller

This block sequences a counter-ramp analog-to-digital conversion. A one-clock request pulse starts a conversion. The block then tells an external sample-and-hold to freeze the analog input and clears an internal up-counter. The counter drives the code input of an external DAC. An external comparator reports when the DAC level has risen above the held input.

The counter steps up by one on every clock until the comparator trips. It also stops if the counter reaches its all-ones value without a trip. The counter value at the stopping clock is captured as the result. The hold command is then released and a done flag is raised. The flag stays up until the next request. The conversion time depends on the input. The block reports how many counting clocks the last conversion took.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: A request seen while idle or done moves the block to a clear step on the next clock, and the code output is 0 on the first counting clock after that.
- R2: The hold output is 1 from the clock after an accepted request until the conversion stops, and it is 0 while idle or done.
- R3: While counting, the code output rises by exactly one per clock.
- R4: When the comparator input is 1 on a counting clock, counting stops and the result equals the code value of that clock.
- R5: The done output rises when a conversion stops and stays 1, with the result unchanged, until the next request; it is 0 on the clock after that request.
- R6: If the code reaches all ones (255 for the default width of 8) without a comparator trip, the conversion ends with result all ones and the code does not wrap to 0.
- R7: The cycle-count output equals the number of counting clocks of the last conversion, the stopping clock included. Input code v below full scale gives v+2, and the worst case is 2^W clocks.
- R8: A request that arrives while a conversion is counting is ignored. The result and the cycle count are those of the uninterrupted conversion.
- R9: After reset, hold, done, code, result and cycle count are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion request pulse |
| cmp_gt | input | 1 | Comparator: DAC level above held input |
| hold | output | 1 | Sample-and-hold freeze command |
| code | output | W | Counter value driving the DAC |
| result | output | W | Captured conversion result |
| done | output | 1 | Conversion complete flag |
| conv_cycles | output | W+1 | Counting clocks of the last conversion |

## Verification
The bench models the analog path as the comparison `code > vin`, which makes the expected result vin+1. The stored input codes tested are 0, 1, a mid-scale value, an odd value, one below full scale and full scale. The low codes expose off-by-one errors in the clear and first-count steps. The top two codes separate a genuine comparator trip from the saturation stop, and both must give result 255 after 256 clocks. A request injected mid-count and a back-to-back restart from the done state show whether requests are filtered and whether the done flag clears.

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         cmp_gt,
  output logic         hold,
  output logic [W-1:0] code,
  output logic [W-1:0] result,
  output logic         done,
  output logic [W:0]   conv_cycles
);
  localparam logic [W-1:0] FULL = '1;

  typedef enum logic [1:0] {S_IDLE, S_CLEAR, S_COUNT, S_DONE} st_t;
  st_t state;

  assign hold = (state == S_CLEAR) || (state == S_COUNT);
  assign done = (state == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      code        <= '0;
      result      <= '0;
      conv_cycles <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: if (start) state <= S_CLEAR;
        S_CLEAR: begin
          code        <= '0;
          conv_cycles <= '0;
          state       <= S_COUNT;
        end
        S_COUNT: begin
          conv_cycles <= conv_cycles + 1'b1;
          if (cmp_gt || code == FULL) begin
            result <= code;
            state  <= S_DONE;
          end else begin
            code <= code + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ramp_adc_ctrl_chk.sv
module ramp_adc_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         cmp_gt,
  input logic         hold,
  input logic [W-1:0] code,
  input logic [W-1:0] result,
  input logic         done
);
  AST_CLEAR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !$past(hold)) |=> (code == '0)); // R1

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold) && $past(hold, 2)) |-> (code == W'($past(code) + 1'b1))); // R3

  AST_TRIP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold) && cmp_gt) |=> (done && result == $past(code))); // R4

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !hold); // R2

  AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(result)); // R5
endmodule

bind ramp_adc_ctrl ramp_adc_ctrl_chk #(.W(W)) u_chk (.*);

// File: tb/tb_ramp_adc_ctrl.sv
`timescale 1ns/1ps
module tb_ramp_adc_ctrl;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0] vin = '0;
  logic hold, done, cmp_gt;
  logic [W-1:0] code, result;
  logic [W:0] conv_cycles;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;
  assign cmp_gt = (code > vin);

  ramp_adc_ctrl #(.W(W)) dut (.clk(clk), .rst_n(rst_n), .start(start), .cmp_gt(cmp_gt),
    .hold(hold), .code(code), .result(result), .done(done), .conv_cycles(conv_cycles));

  // {input code, expected result, expected counting clocks}
  localparam int VEC [6][3] = '{'{0,1,2}, '{1,2,3}, '{100,101,102},
                                '{37,38,39}, '{254,255,256}, '{255,255,256}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk("R5 done reached", int'(done), 1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 hold", int'(hold), 0);
    chk("R9 done", int'(done), 0);
    chk("R9 code", int'(code), 0);
    chk("R9 result", int'(result), 0);
    chk("R9 cycles", int'(conv_cycles), 0);
    rst_n = 1;

    foreach (VEC[i]) begin
      vin = W'(VEC[i][0]);
      pulse_start();
      chk("R2 hold in clear", int'(hold), 1);
      chk("R5 done cleared", int'(done), 0);
      @(negedge clk);
      chk("R1 first code", int'(code), 0);
      @(negedge clk);
      if (!done) chk("R3 second code", int'(code), 1);
      wait_done();
      chk("R4 result", int'(result), VEC[i][1]);
      chk("R7 cycles", int'(conv_cycles), VEC[i][2]);
      chk("R2 hold released", int'(hold), 0);
    end

    // R6: full scale saturates without wrapping
    vin = '1;
    pulse_start();
    wait_done();
    chk("R6 result full", int'(result), 255);
    chk("R6 code no wrap", int'(code), 255);
    repeat (5) @(negedge clk);
    chk("R5 done held", int'(done), 1);
    chk("R5 result held", int'(result), 255);

    // R8: request mid-count is ignored
    vin = 8'd200;
    pulse_start();
    repeat (20) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    chk("R8 still counting", int'(hold), 1);
    wait_done();
    chk("R8 result", int'(result), 201);
    chk("R8 cycles", int'(conv_cycles), 202);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule